// File: doc/BRIEF.md
# Byte-Order-Selectable Split Load Unit

This block serves 16-bit, 32-bit and 64-bit loads at any byte address from a memory whose read port is 32 bits wide and word-aligned. A core raises a request with a byte address, a size code and a byte-order bit. The unit reads every memory word that the item touches, one word per cycle. It keeps the returned words in a small window and then builds the value in the byte order the request asked for. The result is zero-extended to 64 bits and comes back with a one-cycle completion pulse.

The controller is a four-state machine. IDLE holds the unit ready and takes a request (IDLE→ISSUE on a valid request). ISSUE sends one word read per cycle, and it stays there until the last needed word has gone out (ISSUE→ISSUE, then ISSUE→DRAIN). DRAIN waits one cycle for the last word to come back (DRAIN→RESP). RESP presents the result for one cycle (RESP→IDLE). A request is taken only in IDLE, and anything offered in the other states is ignored. The number of words read depends only on the low two address bits and the size. This covers the case of an item that crosses into a second word, and a misaligned doubleword that spans three words.

Top module: `split_load_unit`

## Requirements
- R1: `req_ready` is high only in IDLE. A request is taken on a rising clock edge where `req_valid` and `req_ready` are both high. From the next cycle `req_ready` stays low until the cycle after the `done` pulse.
- R2: Each read puts `mem_rd` high with `mem_addr` set to a word address. The first read uses the request address with bits 1:0 cleared, and each later read of the same load adds 4.
- R3: With byte offset o = addr[1:0] and size in bytes n, the unit issues exactly (o+n+3)/4 reads, rounded down. A halfword needs one read at offsets 0–2 and two at offset 3. A word needs one read when aligned and two otherwise. A doubleword needs two reads at offset 0 and three at offsets 1–3.
- R4: Memory byte lane k (`mem_rdata[8k+7:8k]`) holds the byte at word address + k. With `req_big`=0 (little-endian), result byte j is the memory byte at addr+j.
- R5: With `req_big`=1 (big-endian), result byte j is the memory byte at addr+n−1−j, so the lowest address holds the most significant byte.
- R6: Size code 0 selects 2 bytes and code 1 selects 4 bytes. Codes 2 and 3 both select 8 bytes. Result bits above 8n are zero.
- R7: `done` is high for exactly one cycle, and `done_data` holds the result in that cycle. Counting the accepting edge as edge 0, `done` is high in the cycle that follows edge reads+1.
- R8: `done_data` is zero in every cycle where `done` is low.
- R9: Address, size and byte-order inputs are sampled only at acceptance. Changing them, or holding `req_valid` high, while the unit is busy does not change the reads or the result of the load in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Unit idle, request will be taken |
| req_addr | input | AW | Byte address of the item |
| req_size | input | 2 | Size code: 0 = 16 bit, 1 = 32 bit, 2/3 = 64 bit |
| req_big | input | 1 | 1 = big-endian, 0 = little-endian |
| done | output | 1 | One-cycle completion pulse |
| done_data | output | 64 | Assembled, zero-extended value |
| mem_rd | output | 1 | Word read strobe |
| mem_addr | output | AW | Word-aligned byte address of the read |
| mem_rdata | input | 32 | Read data, valid the cycle after the read |

## Verification
The assertions assume that the memory returns data in exactly the cycle after each `mem_rd`, with no stall and no gaps. They also assume reset is held low long enough to clear the state register before any request. The bench memory model is a registered byte array that always responds with that one-cycle latency. It drives requests only at falling edges, so stimulus never races the controller's edge. Addresses are kept inside the modelled 64-byte space, and the model and the expected values wrap consistently.

// File: rtl/sld_pkg.sv
package sld_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DRAIN = 2'd2,
        ST_RESP  = 2'd3
    } sld_state_e;

    localparam int unsigned WORD_BYTES = 4;
    localparam int unsigned MAX_WORDS  = 3;
    localparam int unsigned RES_BYTES  = 8;
    localparam int unsigned WIN_BYTES  = WORD_BYTES * MAX_WORDS;

    // Size code to byte count: 0 -> 2, 1 -> 4, 2/3 -> 8.
    function automatic logic [3:0] size_bytes(input logic [1:0] code);
        logic [3:0] n;
        case (code)
            2'd0:    n = 4'd2;
            2'd1:    n = 4'd4;
            default: n = 4'd8;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/sld_ctrl.sv
module sld_ctrl
    import sld_pkg::*;
#(
    parameter int unsigned AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic [1:0]    req_size,
    input  logic          req_big,
    output logic          req_ready,
    output logic          start,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    output logic          done,
    output logic [1:0]    lat_off,
    output logic [3:0]    lat_nbytes,
    output logic          lat_big
);

    localparam int unsigned WAW = AW - 2;

    sld_state_e     state, state_nx;
    logic [WAW-1:0] base_word;
    logic [1:0]     nwords;
    logic [1:0]     issue_cnt;
    logic [4:0]     span_sum;
    logic           last_issue;

    assign span_sum   = 5'(req_addr[1:0]) + 5'(size_bytes(req_size)) + 5'd3;
    assign last_issue = (issue_cnt == nwords - 2'd1);

    // State register and request latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            base_word  <= '0;
            lat_off    <= '0;
            lat_nbytes <= 4'd2;
            lat_big    <= 1'b0;
            nwords     <= 2'd1;
            issue_cnt  <= '0;
        end else begin
            state <= state_nx;
            if (start) begin
                base_word  <= req_addr[AW-1:2];
                lat_off    <= req_addr[1:0];
                lat_nbytes <= size_bytes(req_size);
                lat_big    <= req_big;
                nwords     <= span_sum[3:2];
                issue_cnt  <= '0;
            end else if (state == ST_ISSUE) begin
                issue_cnt  <= issue_cnt + 2'd1;
            end
        end
    end

    // Next state and outputs
    always_comb begin
        state_nx  = state;
        req_ready = 1'b0;
        start     = 1'b0;
        mem_rd    = 1'b0;
        done      = 1'b0;
        mem_addr  = {base_word + WAW'(issue_cnt), 2'b00};
        unique case (state)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    start    = 1'b1;
                    state_nx = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                mem_rd = 1'b1;
                if (last_issue) state_nx = ST_DRAIN;
            end
            ST_DRAIN: begin
                state_nx = ST_RESP;
            end
            ST_RESP: begin
                done     = 1'b1;
                state_nx = ST_IDLE;
            end
        endcase
    end

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R1

    AST_READ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && $past(mem_rd)) |-> (mem_addr == $past(mem_addr) + AW'(4))); // R2

    AST_READS_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && $past(mem_rd) && $past(mem_rd, 2)) |=> !mem_rd); // R3

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

    AST_DONE_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !$past(mem_rd)); // R7

endmodule

// File: rtl/sld_capture.sv
module sld_capture
    import sld_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     mem_rd,
    input  logic [8*WORD_BYTES-1:0]  mem_rdata,
    output logic [8*WIN_BYTES-1:0]   win
);

    localparam int unsigned WBITS = 8 * WORD_BYTES;

    logic       rd_q;
    logic [1:0] slot;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= 1'b0;
            slot <= '0;
        end else begin
            rd_q <= mem_rd;
            if (start)     slot <= '0;
            else if (rd_q) slot <= slot + 2'd1;
        end
    end

    for (genvar g = 0; g < MAX_WORDS; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                win[g*WBITS +: WBITS] <= '0;
            else if (rd_q && (slot == 2'(g)))
                win[g*WBITS +: WBITS] <= mem_rdata;
        end
    end

    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_q |-> (slot < 2'(MAX_WORDS))); // R3

endmodule

// File: rtl/sld_assemble.sv
module sld_assemble
    import sld_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [8*WIN_BYTES-1:0]  win,
    input  logic [1:0]              off,
    input  logic [3:0]              nbytes,
    input  logic                    big,
    input  logic                    done,
    output logic [8*RES_BYTES-1:0]  data
);

    localparam int unsigned LUT = 16;

    logic [7:0] wbyte [LUT];

    for (genvar i = 0; i < LUT; i++) begin : g_win
        if (i < WIN_BYTES) begin : g_live
            assign wbyte[i] = win[i*8 +: 8];
        end else begin : g_pad
            assign wbyte[i] = 8'h00;
        end
    end

    for (genvar j = 0; j < RES_BYTES; j++) begin : g_lane
        logic [3:0] idx;
        logic       used;
        always_comb begin
            if (big) idx = 4'(off) + nbytes - 4'd1 - 4'(j);
            else     idx = 4'(off) + 4'(j);
            used = (4'(j) < nbytes);
        end
        assign data[j*8 +: 8] = (done && used) ? wbyte[idx] : 8'h00;
    end

    AST_ZERO_EXT_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (done && nbytes == 4'd2) |-> (data[63:16] == '0)); // R6

    AST_ZERO_EXT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && nbytes == 4'd4) |-> (data[63:32] == '0)); // R6

endmodule

// File: rtl/split_load_unit.sv
module split_load_unit
    import sld_pkg::*;
#(
    parameter int unsigned AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [1:0]    req_size,
    input  logic          req_big,
    output logic          done,
    output logic [63:0]   done_data,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    input  logic [31:0]   mem_rdata
);

    logic                   start;
    logic [1:0]             lat_off;
    logic [3:0]             lat_nbytes;
    logic                   lat_big;
    logic [8*WIN_BYTES-1:0] win;

    sld_ctrl #(.AW(AW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_size   (req_size),
        .req_big    (req_big),
        .req_ready  (req_ready),
        .start      (start),
        .mem_rd     (mem_rd),
        .mem_addr   (mem_addr),
        .done       (done),
        .lat_off    (lat_off),
        .lat_nbytes (lat_nbytes),
        .lat_big    (lat_big)
    );

    sld_capture u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mem_rd    (mem_rd),
        .mem_rdata (mem_rdata),
        .win       (win)
    );

    sld_assemble u_assemble (
        .clk    (clk),
        .rst_n  (rst_n),
        .win    (win),
        .off    (lat_off),
        .nbytes (lat_nbytes),
        .big    (lat_big),
        .done   (done),
        .data   (done_data)
    );

endmodule

// File: tb/tb_split_load_unit.sv
module tb_split_load_unit;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 16;
    localparam int WATCHDOG   = 100000;
    localparam int NVEC       = 12;
    // {addr[7:0], size[1:0], big}
    localparam logic [10:0] VEC [NVEC] = '{
        {8'd3,  2'd0, 1'b0}, {8'd3,  2'd0, 1'b1}, {8'd2,  2'd0, 1'b1},
        {8'd4,  2'd1, 1'b1}, {8'd5,  2'd1, 1'b0}, {8'd7,  2'd1, 1'b1},
        {8'd8,  2'd2, 1'b0}, {8'd9,  2'd2, 1'b1}, {8'd11, 2'd2, 1'b0},
        {8'd13, 2'd3, 1'b1}, {8'd60, 2'd2, 1'b0}, {8'd62, 2'd1, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_size = '0;
    logic          req_big = 1'b0;
    logic          done;
    logic [63:0]   done_data;
    logic          mem_rd;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_rdata = '0;

    logic [7:0] mem [64];
    int checks = 0;
    int errors = 0;
    int cycles = 0;

    split_load_unit #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .req_big(req_big),
        .done(done), .done_data(done_data), .mem_rd(mem_rd),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (mem_rd)
            mem_rdata <= {mem[6'(mem_addr + 3)], mem[6'(mem_addr + 2)],
                          mem[6'(mem_addr + 1)], mem[6'(mem_addr)]};
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        wait (cycles > WATCHDOG);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected<%0d cycles", cycles, WATCHDOG);
        summary();
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int nbytes_of(input logic [1:0] sz);
        return (sz == 2'd0) ? 2 : (sz == 2'd1) ? 4 : 8;
    endfunction

    function automatic logic [63:0] model(input logic [AW-1:0] a, input logic [1:0] sz,
                                          input logic bg);
        logic [63:0] v = '0;
        int n = nbytes_of(sz);
        for (int j = 0; j < n; j++)
            v[j*8 +: 8] = mem[6'(a + AW'(bg ? n - 1 - j : j))];
        return v;
    endfunction

    task automatic do_load(input logic [AW-1:0] a, input logic [1:0] sz, input logic bg,
                           input bit disturb);
        int n = nbytes_of(sz);
        int exp_reads = (int'(a[1:0]) + n + 3) / 4;
        int reads = 0;
        int k;
        logic [63:0] exp_v = model(a, sz, bg);
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready before request", 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_addr = a; req_size = sz; req_big = bg;
        @(negedge clk);
        req_valid = disturb;
        if (disturb) begin
            req_addr = a + AW'(5); req_big = ~bg; req_size = sz ^ 2'd1;
        end
        for (k = 1; k < 20; k++) begin
            if (done) break;
            if (req_ready) chk(1'b0, "R1 ready while busy", 64'(req_ready), 64'd0);
            if (mem_rd) begin
                chk(mem_addr == ((a & ~AW'(3)) + AW'(4 * reads)), "R2 read address",
                    64'(mem_addr), 64'((a & ~AW'(3)) + AW'(4 * reads)));
                reads++;
            end
            @(negedge clk);
        end
        chk(reads == exp_reads, disturb ? "R9 R3 read count" : "R3 read count",
            64'(reads), 64'(exp_reads));
        chk(k == exp_reads + 2, "R7 done latency", 64'(k), 64'(exp_reads + 2));
        chk(done_data == exp_v, disturb ? "R9 result" : (bg ? "R5 big-endian value" :
            "R4 little-endian value"), done_data, exp_v);
        req_valid = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R7 single pulse", 64'(done), 64'd0);
        chk(done_data == 64'd0, "R8 data idle zero", done_data, 64'd0);
        chk(req_ready == 1'b1, "R1 ready after done", 64'(req_ready), 64'd1);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 8'((i * 37 + 11) ^ (i << 3));
        mem[0] = 8'h11; mem[1] = 8'h22; mem[2] = 8'h33; mem[3] = 8'h44;
        repeat (3) @(negedge clk);
        // Reset state
        chk(req_ready == 1'b1, "R1 reset ready", 64'(req_ready), 64'd1);
        chk(done == 1'b0, "R7 reset done", 64'(done), 64'd0);
        chk(mem_rd == 1'b0, "R2 reset no read", 64'(mem_rd), 64'd0);
        chk(done_data == 64'd0, "R8 reset data", done_data, 64'd0);
        rst_n = 1'b1;

        // Known layout: bytes 11,22,33,44 at address 0
        do_load(AW'(0), 2'd1, 1'b1, 1'b0);
        chk(model(AW'(0), 2'd1, 1'b1) == 64'h11223344, "R5 reference layout",
            model(AW'(0), 2'd1, 1'b1), 64'h11223344);
        do_load(AW'(0), 2'd1, 1'b0, 1'b0);
        chk(model(AW'(0), 2'd1, 1'b0) == 64'h44332211, "R4 reference layout",
            model(AW'(0), 2'd1, 1'b0), 64'h44332211);

        // Table of corner vectors
        for (int v = 0; v < NVEC; v++)
            do_load(AW'(VEC[v][10:3]), VEC[v][2:1], VEC[v][0], 1'b0);

        // Sweep: every size code, offsets across two words, both modes (R6)
        for (int s = 0; s < 4; s++)
            for (int a = 0; a < 12; a++)
                for (int b = 0; b < 2; b++)
                    do_load(AW'(a + 16), 2'(s), 1'(b), 1'b0);

        // Inputs changing while busy (R9)
        do_load(AW'(3), 2'd0, 1'b1, 1'b1);
        do_load(AW'(21), 2'd2, 1'b0, 1'b1);
        do_load(AW'(30), 2'd1, 1'b1, 1'b1);

        summary();
    end

endmodule